// File: doc/BRIEF.md
# Next Program Counter Unit

This block owns the program counter of a single-issue 32-bit processor and decides, every cycle, which address is fetched next. The decode stage hands it a 3-bit flow kind together with the raw 16-bit branch displacement, the 26-bit jump field, the two register operands that a conditional branch compares, and the register value used by register-indirect jumps. From these and the current PC the unit produces the next PC, a redirect flag, the return address for call-type jumps, and a flag for a register-indirect target that is not word aligned.

The next PC is combinational from the current inputs and the PC register. The register loads that value on a rising clock edge when the advance enable is high and holds otherwise. A synchronous active-high reset puts the PC at a start address set by a parameter. Branch targets are relative to the already-incremented PC, in units of words. Absolute jumps are pseudo-direct: they replace the low 28 bits and keep the top 4 bits of the incremented PC.

Top module: `pc_sequencer`

## Requirements
- R1: While reset is high at a rising clock edge, the PC register becomes the parameter `RESET_PC` (default 0x0040_0000), whatever the other inputs are.
- R2: For flow kind 0 (sequential), the next PC is PC+4 modulo 2^32, so 0xFFFF_FFFC wraps to 0, and the redirect flag is 0.
- R3: For flow kind 1 (branch if equal), when the two operands are equal the next PC is PC+4 plus the sign-extended displacement times 4, and the redirect flag is 1; otherwise the next PC is PC+4 and the flag is 0.
- R4: For flow kind 2 (branch if not equal), the branch is taken when the operands differ and not taken when they match, with the same target and fall-through as R3.
- R5: For flow kinds 3 (jump) and 4 (jump and link), the next PC is bits 31..28 of PC+4 followed by the 26-bit jump field followed by two zero bits, and the redirect flag is 1.
- R6: The link address output always shows PC+4; the link write strobe is 1 for flow kind 4 and 0 for every other kind.
- R7: For flow kind 5 (register jump), the next PC is the register value unchanged, including its low two bits, and the redirect flag is 1.
- R8: The misaligned flag is 1 exactly when flow kind is 5 and bit 1 or bit 0 of the register value is set; all other kinds leave it 0.
- R9: At a rising edge with reset low and the advance enable high, the PC register takes the next PC; with the enable low it keeps its value.
- R10: Flow kinds 6 and 7 are reserved and behave as sequential flow: next PC is PC+4, redirect, link strobe and misaligned flag are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| adv_en | input | 1 | Load the next PC on this edge |
| flow_kind | input | 3 | Control flow kind code (see R2-R10 codes) |
| br_disp | input | 16 | Signed branch displacement in words |
| jmp_field | input | 26 | Word address field of an absolute jump |
| opnd_a | input | 32 | First compared register operand |
| opnd_b | input | 32 | Second compared register operand |
| jreg_val | input | 32 | Register value for register jumps |
| pc_q | output | 32 | Current program counter |
| next_pc | output | 32 | Address to be loaded on the next enabled edge |
| redirect | output | 1 | Flow leaves the sequential path |
| link_addr | output | 32 | Return address (PC+4) |
| link_we | output | 1 | Return address is to be written |
| misalign | output | 1 | Register jump target is not word aligned |

## Verification
The bench goes after the sign of the displacement at its extremes (0x7FFF and 0x8000): a design that zero-extends or forgets the scaling lands hundreds of kilobytes off. Jumps are taken from a PC whose top nibble is nonzero and from the last word of a 256 MB region, so a design that uses the current PC instead of PC+4 for the upper bits, or clears them, gives a different target. Operands that differ in only the top or bottom bit catch a truncated comparator, the reserved kinds catch a decoder that treats them as jumps, and a register jump to each low-bit pattern catches a flag tied to the wrong bits or a target that silently clears them. The enable is dropped on a redirecting kind to show the PC holds.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int XLEN     = 32;
    localparam int DISP_W   = 16;
    localparam int JFIELD_W = 26;
    localparam int KIND_W   = 3;
    localparam int INSN_BYTES = 4;
    localparam int ALIGN_W  = $clog2(INSN_BYTES);
    localparam int REGION_W = XLEN - JFIELD_W - ALIGN_W;

    typedef logic [XLEN-1:0] addr_t;

    typedef enum logic [KIND_W-1:0] {
        FLOW_SEQ   = 3'd0,
        FLOW_BEQ   = 3'd1,
        FLOW_BNE   = 3'd2,
        FLOW_JUMP  = 3'd3,
        FLOW_JLINK = 3'd4,
        FLOW_JREG  = 3'd5
    } flow_e;

    typedef struct packed {
        addr_t seq;
        addr_t branch;
        addr_t jump;
    } target_set_t;

    typedef struct packed {
        addr_t nxt;
        logic  redirect;
        logic  link_we;
        logic  misalign;
    } pick_t;

    function automatic addr_t scale_disp(input logic [DISP_W-1:0] d);
        addr_t ext;
        ext = {{(XLEN-DISP_W){d[DISP_W-1]}}, d};
        return ext << ALIGN_W;
    endfunction

    function automatic addr_t compose_jump(input addr_t incr,
                                           input logic [JFIELD_W-1:0] f);
        return {incr[XLEN-1 -: REGION_W], f, {ALIGN_W{1'b0}}};
    endfunction

endpackage

// File: rtl/npc_target_gen.sv
module npc_target_gen
    import npc_pkg::*;
(
    input  addr_t                 pc_cur,
    input  logic [DISP_W-1:0]     disp,
    input  logic [JFIELD_W-1:0]   jfield,
    output target_set_t           tgt
);
    localparam addr_t STEP = addr_t'(INSN_BYTES);

    addr_t incr;

    always_comb begin
        incr       = pc_cur + STEP;
        tgt.seq    = incr;
        tgt.branch = incr + scale_disp(disp);
        tgt.jump   = compose_jump(incr, jfield);
    end
endmodule

// File: rtl/npc_cond_eval.sv
module npc_cond_eval
    import npc_pkg::*;
#(
    parameter bit XOR_TREE = 1'b1
)(
    input  logic [KIND_W-1:0] kind,
    input  addr_t             a,
    input  addr_t             b,
    output logic              br_take
);
    logic same;

    generate
        if (XOR_TREE) begin : g_xor
            addr_t diff;
            always_comb begin
                diff = a ^ b;
                same = ~(|diff);
            end
        end else begin : g_cmp
            always_comb same = (a == b);
        end
    endgenerate

    always_comb begin
        unique case (kind)
            FLOW_BEQ: br_take = same;
            FLOW_BNE: br_take = ~same;
            default:  br_take = 1'b0;
        endcase
    end
endmodule

// File: rtl/npc_select.sv
module npc_select
    import npc_pkg::*;
(
    input  logic [KIND_W-1:0] kind,
    input  target_set_t       tgt,
    input  logic              br_take,
    input  addr_t             jreg,
    output pick_t             pick
);
    always_comb begin
        pick.nxt      = tgt.seq;
        pick.redirect = 1'b0;
        pick.link_we  = 1'b0;
        pick.misalign = 1'b0;
        case (kind)
            FLOW_BEQ, FLOW_BNE: begin
                if (br_take) begin
                    pick.nxt      = tgt.branch;
                    pick.redirect = 1'b1;
                end
            end
            FLOW_JUMP: begin
                pick.nxt      = tgt.jump;
                pick.redirect = 1'b1;
            end
            FLOW_JLINK: begin
                pick.nxt      = tgt.jump;
                pick.redirect = 1'b1;
                pick.link_we  = 1'b1;
            end
            FLOW_JREG: begin
                pick.nxt      = jreg;
                pick.redirect = 1'b1;
                pick.misalign = |jreg[ALIGN_W-1:0];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import npc_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0040_0000,
    parameter bit          XOR_TREE = 1'b1
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                adv_en,
    input  logic [2:0]          flow_kind,
    input  logic [15:0]         br_disp,
    input  logic [25:0]         jmp_field,
    input  logic [31:0]         opnd_a,
    input  logic [31:0]         opnd_b,
    input  logic [31:0]         jreg_val,
    output logic [31:0]         pc_q,
    output logic [31:0]         next_pc,
    output logic                redirect,
    output logic [31:0]         link_addr,
    output logic                link_we,
    output logic                misalign
);
    target_set_t tgt;
    logic        br_take;
    pick_t       pick;

    npc_target_gen u_tgt (
        .pc_cur (pc_q),
        .disp   (br_disp),
        .jfield (jmp_field),
        .tgt    (tgt)
    );

    npc_cond_eval #(.XOR_TREE(XOR_TREE)) u_cond (
        .kind    (flow_kind),
        .a       (opnd_a),
        .b       (opnd_b),
        .br_take (br_take)
    );

    npc_select u_sel (
        .kind    (flow_kind),
        .tgt     (tgt),
        .br_take (br_take),
        .jreg    (jreg_val),
        .pick    (pick)
    );

    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= RESET_PC;
        else if (adv_en)
            pc_q <= pick.nxt;
    end

    assign next_pc   = pick.nxt;
    assign redirect  = pick.redirect;
    assign link_we   = pick.link_we;
    assign misalign  = pick.misalign;
    assign link_addr = tgt.seq;
endmodule

// File: rtl/npc_checker.sv
module npc_checker #(
    parameter logic [31:0] RESET_PC = 32'h0040_0000
)(
    input logic        clk,
    input logic        rst,
    input logic        adv_en,
    input logic [2:0]  flow_kind,
    input logic [31:0] pc_q,
    input logic [31:0] next_pc,
    input logic        redirect,
    input logic        link_we,
    input logic        misalign
);
    AST_RESET_PC: assert property (@(posedge clk)
        rst |=> pc_q == RESET_PC); // R1

    AST_PC_LOADS: assert property (@(posedge clk) disable iff (rst)
        (!rst && adv_en) |=> pc_q == $past(next_pc)); // R9

    AST_PC_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!rst && !adv_en) |=> $stable(pc_q)); // R9

    AST_SEQ_NO_REDIRECT: assert property (@(posedge clk) disable iff (rst)
        (flow_kind == 3'd0) |-> !redirect); // R2

    AST_LINK_REDIRECTS: assert property (@(posedge clk) disable iff (rst)
        link_we |-> redirect); // R6

    AST_MISALIGN_REDIRECTS: assert property (@(posedge clk) disable iff (rst)
        misalign |-> redirect); // R8

    AST_ALIGN_KEPT: assert property (@(posedge clk) disable iff (rst)
        (pc_q[1:0] == 2'b00 && !misalign) |-> next_pc[1:0] == 2'b00); // R8
endmodule

bind pc_sequencer npc_checker #(.RESET_PC(RESET_PC)) u_npc_chk (
    .clk       (clk),
    .rst       (rst),
    .adv_en    (adv_en),
    .flow_kind (flow_kind),
    .pc_q      (pc_q),
    .next_pc   (next_pc),
    .redirect  (redirect),
    .link_we   (link_we),
    .misalign  (misalign)
);

// File: tb/pc_sequencer_tb.sv
module pc_sequencer_tb_top;
    localparam logic [31:0] START = 32'h0040_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        adv_en = 1'b0;
    logic [2:0]  flow_kind = 3'd0;
    logic [15:0] br_disp = '0;
    logic [25:0] jmp_field = '0;
    logic [31:0] opnd_a = '0, opnd_b = '0, jreg_val = '0;
    logic [31:0] pc_q, next_pc, link_addr;
    logic        redirect, link_we, misalign;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pc_sequencer #(.RESET_PC(START)) dut_i (
        .clk(clk), .rst(rst), .adv_en(adv_en), .flow_kind(flow_kind),
        .br_disp(br_disp), .jmp_field(jmp_field), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .jreg_val(jreg_val), .pc_q(pc_q),
        .next_pc(next_pc), .redirect(redirect), .link_addr(link_addr),
        .link_we(link_we), .misalign(misalign)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic string req_of(input int k);
        case (k)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R5";
            5: return "R7";
            default: return "R10";
        endcase
    endfunction

    function automatic logic [31:0] model_next(input logic [31:0] pc, input int k,
            input logic [15:0] d, input logic [25:0] f,
            input logic [31:0] a, input logic [31:0] b, input logic [31:0] r);
        logic [31:0] inc, ext;
        inc = pc + 32'd4;
        ext = {{16{d[15]}}, d};
        case (k)
            1: return (a == b) ? inc + ext * 32'd4 : inc;
            2: return (a != b) ? inc + ext * 32'd4 : inc;
            3, 4: return (inc & 32'hF000_0000) | ({6'd0, f} * 32'd4);
            5: return r;
            default: return inc;
        endcase
    endfunction

    function automatic logic model_redirect(input int k, input logic [31:0] a,
                                            input logic [31:0] b);
        case (k)
            1: return a == b;
            2: return a != b;
            3, 4, 5: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic load_pc(input logic [31:0] v);
        flow_kind = 3'd5; jreg_val = v; adv_en = 1'b1;
        step();
        adv_en = 1'b0;
        chk("R7", "pc after register jump", pc_q, v);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] pcs [4];
        logic [15:0] disps [6];
        logic [31:0] opa [3];
        logic [31:0] opb [3];
        logic [31:0] p0;
        pcs[0] = 32'h0040_0000; pcs[1] = 32'hF000_0100;
        pcs[2] = 32'h0FFF_FFFC; pcs[3] = 32'hFFFF_FFFC;
        disps[0] = 16'h0000; disps[1] = 16'h0001; disps[2] = 16'hFFFF;
        disps[3] = 16'h7FFF; disps[4] = 16'h8000; disps[5] = 16'h0002;
        opa[0] = 32'h1234_5678; opb[0] = 32'h1234_5678;
        opa[1] = 32'h8000_0000; opb[1] = 32'h0000_0000;
        opa[2] = 32'h0000_0001; opb[2] = 32'h0000_0000;

        // R1: reset with enable and a jump presented
        adv_en = 1'b1; flow_kind = 3'd3; jmp_field = 26'h3FF_FFFF;
        step(); step();
        chk("R1", "pc in reset", pc_q, START);
        rst = 1'b0; adv_en = 1'b0; flow_kind = 3'd0;
        #1;
        chk("R1", "pc after reset release", pc_q, START);

        // R9: enable low holds on a redirecting kind
        @(negedge clk);
        flow_kind = 3'd3; jmp_field = 26'h0000_123;
        step();
        chk("R9", "pc held with enable low", pc_q, START);
        adv_en = 1'b1; flow_kind = 3'd0;
        step();
        chk("R9", "pc loads with enable high", pc_q, START + 32'd4);
        adv_en = 1'b0;

        // sweep of kinds, displacements, operand pairs over several PCs
        for (int pi = 0; pi < 4; pi++) begin
            load_pc(pcs[pi]);
            for (int k = 0; k < 8; k++) begin
                for (int di = 0; di < 6; di++) begin
                    for (int oi = 0; oi < 3; oi++) begin
                        flow_kind = 3'(k); br_disp = disps[di];
                        jmp_field = {disps[di], 10'h2A5} ^ 26'(oi);
                        opnd_a = opa[oi]; opnd_b = opb[oi];
                        jreg_val = pcs[pi] ^ {30'h0ABC_DEF0, 2'(di)};
                        #1;
                        chk(req_of(k), "next pc", next_pc,
                            model_next(pcs[pi], k, br_disp, jmp_field,
                                       opnd_a, opnd_b, jreg_val));
                        chk(req_of(k), "redirect", {31'd0, redirect},
                            {31'd0, model_redirect(k, opnd_a, opnd_b)});
                        chk("R6", "link addr", link_addr, pcs[pi] + 32'd4);
                        chk("R6", "link strobe", {31'd0, link_we},
                            {31'd0, (k == 4)});
                        chk("R8", "misalign", {31'd0, misalign},
                            {31'd0, (k == 5) && (jreg_val[1:0] != 2'b00)});
                    end
                end
            end
        end

        // R2: wraparound through the register
        load_pc(32'hFFFF_FFFC);
        flow_kind = 3'd0; adv_en = 1'b1;
        step();
        chk("R2", "pc wraps to zero", pc_q, 32'h0);
        adv_en = 1'b0;

        // R4 and R5 worked example
        load_pc(32'd80012);
        flow_kind = 3'd2; br_disp = 16'd2; opnd_a = 32'd5; opnd_b = 32'd6;
        adv_en = 1'b1;
        step();
        chk("R4", "bne example target", pc_q, 32'd80024);
        adv_en = 1'b0;
        load_pc(32'd80020);
        flow_kind = 3'd3; jmp_field = 26'd20000; adv_en = 1'b1;
        step();
        chk("R5", "jump example target", pc_q, 32'd80000);
        adv_en = 1'b0;

        // R5: upper bits taken from PC+4 crossing a 256 MB region
        load_pc(32'h1FFF_FFFC);
        flow_kind = 3'd4; jmp_field = 26'h000_0010; #1;
        chk("R5", "region from incremented pc", next_pc, 32'h2000_0040);
        chk("R6", "link on region edge", link_addr, 32'h2000_0000);

        // R7/R8: register jump keeps low bits and flags each pattern
        for (int lb = 0; lb < 4; lb++) begin
            p0 = 32'h0000_8000 | 32'(lb);
            flow_kind = 3'd5; jreg_val = p0; adv_en = 1'b1;
            #1;
            chk("R8", "misalign pattern", {31'd0, misalign}, {31'd0, lb != 0});
            step();
            chk("R7", "unaligned target loaded", pc_q, p0);
        end
        adv_en = 1'b0;

        // R1: reset mid-run
        rst = 1'b1; step(); rst = 1'b0;
        chk("R1", "pc after second reset", pc_q, START);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule